// File: doc/BRIEF.md
# Trigger Interrupt Source Controller

This block gathers assertion events from a bank of trigger lines (eight TTL-level lines and two ECL-level lines) and from a single location-monitor event input. Each trigger line passes through a synchronizer and a rising-edge detector. A per-line enable mask gates each detected edge into a sticky per-line source bit. Any gated edge also sets a trigger summary flag. A location-monitor pulse sets a second summary flag.

The two summary flags drive a bus interrupt request. The request is enabled through active-low control bits and placed on one of seven request levels by an inverted 3-bit level code. An interrupt-acknowledge strobe returns a status word whose low byte carries the module's logical address. An ordinary read of the same word returns all ones in that byte. Both kinds of status access clear the summary flags. Software clears source bits one at a time by writing ones to a clear offset.

The register port is a single-cycle strobe interface with byte offsets inside the module's 64-byte block. Read data is combinational from the stored state, and every read side effect takes place at the clock edge that ends the access. Reset is asynchronous and active low, and is expected to be released synchronously to `clk`.

Top module: `trig_irq_ctrl`

## Requirements
- R1: A write to offset 0x2E loads the line enable mask. Bits 7:0 map to the TTL lines and bits 9:8 map to the ECL lines, and a 1 enables the line. The mask resets to 0, so a line whose mask bit is 0 never sets its source bit.
- R2: A low-to-high transition on an enabled line sets its source bit. The bit reads 1 after the third rising clock edge that follows the transition. A line held high produces exactly one event.
- R3: A read of offset 0x2E returns the source bits in bits 9:0, with line i in bit i, and returns 0 in bits 15:10. Source bits stay set until they are cleared.
- R4: A write to offset 0x30 clears each source bit whose data bit is 1, and leaves the bits whose data bit is 0 unchanged. A new event in the same cycle as the clear leaves its bit set.
- R5: The status word at offset 0x2A carries the location-monitor summary in bit 9 and the trigger summary in bit 8, and reads 0 in bits 15:10. An enabled line event sets bit 8. A cycle with the location-monitor input high sets bit 9.
- R6: An ordinary read of the status word returns 0xFF in bits 7:0. While the acknowledge strobe is high, bits 7:0 return the logical-address input.
- R7: A status read or an acknowledge clears both summary flags at the edge that ends the access. An event in that same cycle keeps its flag set.
- R8: The control word at offset 0x2C holds three active-low enables: bit 9 for the location monitor, bit 8 for the triggers and bit 7 for the request. It also holds the level code in bits 5:3. All other bits read 1, and the word resets to 0xFFFF.
- R9: A level code c from 0 to 6 selects request level 7-c, which appears on `irq_o` bit 6-c. Code 7 drives no request, and `irq_o` never has more than one bit set.
- R10: `irq_o` is nonzero exactly when the request enable is low and at least one summary flag is set whose own enable is also low.
- R11: A read of any offset other than 0x2A, 0x2C and 0x2E returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ttl_trig_i | input | 8 | TTL trigger lines, asynchronous |
| ecl_trig_i | input | 2 | ECL trigger lines, asynchronous |
| locmon_evt_i | input | 1 | Location-monitor event, synchronous to clk |
| la_i | input | 8 | Module logical address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Byte offset within the module block |
| reg_wdata_i | input | 16 | Write data |
| iack_i | input | 1 | Interrupt-acknowledge strobe |
| reg_rdata_o | output | 16 | Read or acknowledge data |
| irq_o | output | 7 | One-hot request; bit k is level k+1 |

## Verification
The bench builds the block with its default parameters: eight TTL lines, two ECL lines and a two-stage synchronizer. With these values every line can be swept one at a time, all eight level codes can be walked, and all eight combinations of the three active-low enables can be tried against both summary flags. The expected source vectors, control words and one-hot request vectors are computed arithmetically from the line index, the code or the enable pattern.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned LA_W   = 8;
  localparam int unsigned CODE_W = 3;

  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h2A;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_MSRC = 6'h2E;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h30;

  // bit positions inside the status and control words
  localparam int unsigned BIT_LM   = 9;
  localparam int unsigned BIT_TRG  = 8;
  localparam int unsigned BIT_REQ  = 7;
  localparam int unsigned LVL_LSB  = 3;

  typedef struct packed {
    logic                lm_en_n;
    logic                trg_en_n;
    logic                req_en_n;
    logic [CODE_W-1:0]   lvl;
  } ctl_t;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int unsigned WIDTH  = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] rise_o
);
  localparam int unsigned SW = (STAGES < 2) ? 2 : STAGES;

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [SW-1:0] shf_q, shf_d;
    logic          prev_q;
    logic          synced;

    assign synced = shf_q[SW-1];

    always_comb begin
      shf_d = {shf_q[SW-2:0], line_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shf_q  <= '0;
        prev_q <= 1'b0;
      end else begin
        shf_q  <= shf_d;
        prev_q <= synced;
      end
    end

    assign rise_o[g] = synced & ~prev_q;
  end
endmodule

// File: rtl/trig_src_bank.sv
module trig_src_bank #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise_i,
  input  logic             mask_we_i,
  input  logic [WIDTH-1:0] mask_wdata_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_bits_i,
  output logic [WIDTH-1:0] src_o,
  output logic [WIDTH-1:0] hit_o,
  output logic             hit_any_o
);
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] src_q, src_d;
  logic [WIDTH-1:0] clr_vec;

  assign hit_o     = rise_i & mask_q;
  assign hit_any_o = |hit_o;
  assign clr_vec   = clr_we_i ? clr_bits_i : '0;

  always_comb begin
    src_d = (src_q & ~clr_vec) | hit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else begin
      src_q <= src_d;
    end
  end

  assign src_o = src_q;
endmodule

// File: rtl/irq_level_dec.sv
module irq_level_dec #(
  parameter int unsigned LEVELS = 7,
  parameter int unsigned CODE_W = 3
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              active_i,
  output logic [LEVELS-1:0] irq_o
);
  // code 0 selects the highest level; the all-ones code matches no bit
  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam logic [CODE_W-1:0] MATCH = CODE_W'(LEVELS - 1 - k);
    assign irq_o[k] = active_i && (code_i == MATCH);
  end
endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
  import trig_irq_pkg::*;
#(
  parameter int unsigned N_TTL       = 8,
  parameter int unsigned N_ECL       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_LEVELS    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TTL-1:0]  ttl_trig_i,
  input  logic [N_ECL-1:0]  ecl_trig_i,
  input  logic              locmon_evt_i,
  input  logic [7:0]        la_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [5:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  input  logic              iack_i,
  output logic [15:0]       reg_rdata_o,
  output logic [N_LEVELS-1:0] irq_o
);
  localparam int unsigned N_LINES = N_TTL + N_ECL;
  localparam int unsigned PAD_W   = DATA_W - N_LINES;

  logic [N_LINES-1:0] lines;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] hit;
  logic [N_LINES-1:0] src_q;
  logic               hit_any;

  logic  sel_stat, sel_ctl, sel_msrc, sel_clr;
  logic  ctl_we, mask_we, clr_we, sum_clr;

  ctl_t  ctl_q, ctl_d;
  logic  sum_trg_q, sum_trg_d;
  logic  sum_lm_q,  sum_lm_d;
  logic  req_active;

  assign lines = {ecl_trig_i, ttl_trig_i};

  // address decode
  assign sel_stat = (reg_addr_i == OFS_STAT);
  assign sel_ctl  = (reg_addr_i == OFS_CTL);
  assign sel_msrc = (reg_addr_i == OFS_MSRC);
  assign sel_clr  = (reg_addr_i == OFS_CLR);

  assign ctl_we  = reg_wr_i && sel_ctl;
  assign mask_we = reg_wr_i && sel_msrc;
  assign clr_we  = reg_wr_i && sel_clr;
  assign sum_clr = iack_i || (reg_rd_i && sel_stat);

  trig_edge_sync #(
    .WIDTH  (N_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (lines),
    .rise_o (rise)
  );

  trig_src_bank #(
    .WIDTH (N_LINES)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_i       (rise),
    .mask_we_i    (mask_we),
    .mask_wdata_i (reg_wdata_i[N_LINES-1:0]),
    .clr_we_i     (clr_we),
    .clr_bits_i   (reg_wdata_i[N_LINES-1:0]),
    .src_o        (src_q),
    .hit_o        (hit),
    .hit_any_o    (hit_any)
  );

  // next state: control and summary flags
  always_comb begin
    ctl_d.lm_en_n  = reg_wdata_i[BIT_LM];
    ctl_d.trg_en_n = reg_wdata_i[BIT_TRG];
    ctl_d.req_en_n = reg_wdata_i[BIT_REQ];
    ctl_d.lvl      = reg_wdata_i[LVL_LSB +: CODE_W];
    sum_trg_d      = (sum_trg_q & ~sum_clr) | hit_any;
    sum_lm_d       = (sum_lm_q  & ~sum_clr) | locmon_evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '1;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_trg_q <= 1'b0;
      sum_lm_q  <= 1'b0;
    end else begin
      sum_trg_q <= sum_trg_d;
      sum_lm_q  <= sum_lm_d;
    end
  end

  // request generation
  assign req_active = !ctl_q.req_en_n &&
                      ((sum_trg_q && !ctl_q.trg_en_n) ||
                       (sum_lm_q  && !ctl_q.lm_en_n));

  irq_level_dec #(
    .LEVELS (N_LEVELS),
    .CODE_W (CODE_W)
  ) u_dec (
    .code_i   (ctl_q.lvl),
    .active_i (req_active),
    .irq_o    (irq_o)
  );

  // read data
  always_comb begin
    logic [DATA_W-1:0] stat_w, ctl_w;
    stat_w          = '0;
    stat_w[BIT_LM]  = sum_lm_q;
    stat_w[BIT_TRG] = sum_trg_q;
    stat_w[LA_W-1:0] = iack_i ? la_i : '1;

    ctl_w                       = '1;
    ctl_w[BIT_LM]               = ctl_q.lm_en_n;
    ctl_w[BIT_TRG]              = ctl_q.trg_en_n;
    ctl_w[BIT_REQ]              = ctl_q.req_en_n;
    ctl_w[LVL_LSB +: CODE_W]    = ctl_q.lvl;

    if (iack_i)        reg_rdata_o = stat_w;
    else if (sel_stat) reg_rdata_o = stat_w;
    else if (sel_ctl)  reg_rdata_o = ctl_w;
    else if (sel_msrc) reg_rdata_o = {{PAD_W{1'b0}}, src_q};
    else               reg_rdata_o = '0;
  end
endmodule

// File: rtl/trig_irq_chk.sv
module trig_irq_chk #(
  parameter int unsigned N_LINES  = 10,
  parameter int unsigned N_LEVELS = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_i,
  input logic                reg_rd_i,
  input logic [5:0]          reg_addr_i,
  input logic [15:0]         reg_wdata_i,
  input logic                iack_i,
  input logic                locmon_evt_i,
  input logic [7:0]          la_i,
  input logic [15:0]         reg_rdata_o,
  input logic [N_LEVELS-1:0] irq_o,
  input logic [N_LINES-1:0]  hit,
  input logic [N_LINES-1:0]  src_q,
  input logic                sum_trg_q,
  input logic                sum_lm_q
);
  assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  assert_req_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 6'h2C && reg_wdata_i[7]) |=> (irq_o == '0));

  assert_sum_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((iack_i || (reg_rd_i && reg_addr_i == 6'h2A)) && !locmon_evt_i && hit == '0)
      |=> (!sum_trg_q && !sum_lm_q));

  assert_src_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 6'h30)
      |=> ((src_q & $past(reg_wdata_i[N_LINES-1:0] & ~hit)) == '0));

  assert_src_by_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q & ~$past(src_q) & ~$past(hit)) == '0));

  assert_stat_fmt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && !iack_i && reg_addr_i == 6'h2A)
      |-> (reg_rdata_o[15:10] == '0 && reg_rdata_o[7:0] == 8'hFF));

  assert_iack_la_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iack_i |-> (reg_rdata_o[7:0] == la_i));
endmodule

bind trig_irq_ctrl trig_irq_chk #(
  .N_LINES  (N_TTL + N_ECL),
  .N_LEVELS (N_LEVELS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_i     (reg_wr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .iack_i       (iack_i),
  .locmon_evt_i (locmon_evt_i),
  .la_i         (la_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_o        (irq_o),
  .hit          (hit),
  .src_q        (src_q),
  .sum_trg_q    (sum_trg_q),
  .sum_lm_q     (sum_lm_q)
);

// File: tb/tb_trig_irq_ctrl.sv
`timescale 1ns/1ps
module tb_trig_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  lines;
  logic        locmon;
  logic [7:0]  la;
  logic        wr, rd, iack;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [6:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_irq_ctrl dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ttl_trig_i   (lines[7:0]),
    .ecl_trig_i   (lines[9:8]),
    .locmon_evt_i (locmon),
    .la_i         (la),
    .reg_wr_i     (wr),
    .reg_rd_i     (rd),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .iack_i       (iack),
    .reg_rdata_o  (rdata),
    .irq_o        (irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 6'h3F; wdata = '0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0; addr = 6'h3F;
  endtask

  task automatic iack_cycle(output logic [15:0] d);
    @(negedge clk);
    iack = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    iack = 1'b0;
  endtask

  task automatic pulse_lines(input logic [9:0] v);
    @(negedge clk);
    lines = v;
    repeat (4) @(negedge clk);
    lines = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_lm();
    @(negedge clk);
    locmon = 1'b1;
    @(negedge clk);
    locmon = 1'b0;
  endtask

  function automatic logic [15:0] ctl_word(input logic [2:0] en_n, input logic [2:0] code);
    logic [15:0] w;
    w = 16'hFFFF;
    w[9:7] = en_n;
    w[5:3] = code;
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; lines = '0; locmon = 1'b0; la = 8'hA5;
    wr = 1'b0; rd = 1'b0; iack = 1'b0; addr = 6'h3F; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_reg(6'h2C, d); chk(d, 16'hFFFF, "R8 reset control");
    rd_reg(6'h2E, d); chk(d, 16'h0000, "R3 reset source");
    rd_reg(6'h2A, d); chk(d, 16'h00FF, "R6 reset status");
    chk({9'd0, irq}, 16'h0000, "R10 reset irq");

    // mask zero: nothing latches
    pulse_lines(10'h3FF);
    rd_reg(6'h2E, d); chk(d, 16'h0000, "R1 zero mask source");
    rd_reg(6'h2A, d); chk(d, 16'h00FF, "R5 zero mask status");

    // one line enabled at a time
    for (int i = 0; i < 10; i++) begin
      wr_reg(6'h2E, 16'(1 << i));
      wr_reg(6'h30, 16'h03FF);
      pulse_lines(10'h3FF);
      rd_reg(6'h2E, d); chk(d, 16'(1 << i), $sformatf("R1 R2 line %0d source", i));
      rd_reg(6'h2A, d); chk(d, 16'h01FF, $sformatf("R5 line %0d status", i));
      rd_reg(6'h2A, d); chk(d, 16'h00FF, $sformatf("R7 line %0d status cleared", i));
    end

    // edge timing: bit appears after the third edge
    wr_reg(6'h2E, 16'h0004);
    wr_reg(6'h30, 16'h03FF);
    @(negedge clk); lines = 10'h004; addr = 6'h2E;
    @(negedge clk); @(negedge clk);
    #1 chk(rdata, 16'h0000, "R2 source before third edge");
    @(negedge clk);
    #1 chk(rdata, 16'h0004, "R2 source after third edge");
    // held level produces only one event
    wr_reg(6'h30, 16'h0004);
    repeat (6) @(negedge clk);
    rd_reg(6'h2E, d); chk(d, 16'h0000, "R2 held level single event");
    @(negedge clk); lines = '0;
    repeat (3) @(negedge clk);
    rd_reg(6'h2A, d);

    // mask patterns
    for (int p = 0; p < 3; p++) begin
      logic [9:0] m;
      m = (p == 0) ? 10'h155 : (p == 1) ? 10'h2AA : 10'h0F3;
      wr_reg(6'h2E, {6'd0, m});
      wr_reg(6'h30, 16'h03FF);
      pulse_lines(10'h3FF);
      rd_reg(6'h2E, d); chk(d, {6'd0, m}, $sformatf("R1 R3 mask pattern %0d", p));
    end

    // partial clear
    wr_reg(6'h2E, 16'h03FF);
    pulse_lines(10'h3FF);
    wr_reg(6'h30, 16'h00F0);
    rd_reg(6'h2E, d); chk(d, 16'h030F, "R4 partial clear");
    wr_reg(6'h30, 16'h0000);
    rd_reg(6'h2E, d); chk(d, 16'h030F, "R4 zero write no effect");
    rd_reg(6'h2A, d);

    // location monitor and acknowledge
    pulse_lm();
    rd_reg(6'h2A, d); chk(d, 16'h02FF, "R5 location monitor status");
    pulse_lm();
    iack_cycle(d); chk(d, 16'h02A5, "R6 acknowledge word");
    rd_reg(6'h2A, d); chk(d, 16'h00FF, "R7 cleared by acknowledge");

    // level code sweep with trigger summary set
    wr_reg(6'h2E, 16'h0001);
    pulse_lines(10'h001);
    for (int c = 0; c < 8; c++) begin
      logic [6:0] ex;
      wr_reg(6'h2C, ctl_word(3'b100, 3'(c)));
      rd_reg(6'h2C, d); chk(d, ctl_word(3'b100, 3'(c)), $sformatf("R8 control code %0d", c));
      ex = (c == 7) ? 7'h00 : 7'(1 << (6 - c));
      chk({9'd0, irq}, {9'd0, ex}, $sformatf("R9 level code %0d", c));
    end

    // enable combinations with both summaries set
    pulse_lm();
    for (int e = 0; e < 8; e++) begin
      logic [2:0] en;
      logic [6:0] ex;
      en = 3'(e);
      wr_reg(6'h2C, ctl_word(en, 3'd0));
      ex = (!en[0] && (!en[1] || !en[2])) ? 7'h40 : 7'h00;
      chk({9'd0, irq}, {9'd0, ex}, $sformatf("R10 enables %03b", en));
    end
    rd_reg(6'h2A, d); chk(d, 16'h03FF, "R5 both summaries");
    wr_reg(6'h2C, ctl_word(3'b000, 3'd0));
    chk({9'd0, irq}, 16'h0000, "R7 R10 irq drops after status read");
    pulse_lm();
    chk({9'd0, irq}, 16'h0040, "R10 location monitor request");
    wr_reg(6'h2C, ctl_word(3'b100, 3'd0));
    chk({9'd0, irq}, 16'h0000, "R10 location monitor disabled");
    wr_reg(6'h2C, ctl_word(3'b000, 3'd4));
    chk({9'd0, irq}, 16'h0004, "R9 code 4 gives level 3");

    // unmapped offsets
    rd_reg(6'h00, d); chk(d, 16'h0000, "R11 offset 0x00");
    rd_reg(6'h30, d); chk(d, 16'h0000, "R11 offset 0x30");
    rd_reg(6'h3E, d); chk(d, 16'h0000, "R11 offset 0x3E");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule